// File: doc/BRIEF.md
# Power-management status and configuration register

This block is a small byte-wide register. It holds two bits for the controller that produces the sleep-state signal: an enable that stretches that signal's minimum assertion, and a 2-bit duration select. It also holds two sticky status bits, one for a weak battery and one for loss of trickle current. Software reaches it through a single-cycle write strobe with write data, and it can read the register at any time, because the read value is combinational. The register runs on the always-on real-time clock.

Each bit has its own write rule and its own reset source. The stretch enable and the duration select are read/write, and only the always-on domain reset clears them. While the policy lock input is high, the stretch enable ignores writes. The battery-weak bit is cleared when software writes a 0 to it. The battery-weak bit is set when the always-on reset asserts, and no reset clears it. The power-failure bit is cleared when software writes a 1 to it, and loss of trickle current sets it.

A parameter places the power-failure bit in one of two wells:
- In the standby-well variant, the standby reset forces the bit to 1. That reset is sampled on the real-time clock, so a low pulse that falls between two edges is not seen.
- In the always-on variant, the standby reset has no effect on the bit, and the always-on reset clears it.

Assertion of the always-on reset is asynchronous. Its release is synchronized to the clock.

Top module: `pm_cfg_reg`

## Requirements
- R1: While the always-on reset (`rtc_rst_n` low) is asserted, the fields read as follows. The stretch enable reads 0, the duration reads 0 and the battery bit reads 1. The power-failure bit reads 1 in the standby variant and 0 in the always-on variant. Read value: 0x06 in the standby variant, 0x04 in the always-on variant.
- R2: When `lock` is low, a write stores `wr_data[3]` into the stretch enable. The stretch enable appears at `rd_data[3]` and on `stretch_en` from the clock edge that takes the write.
- R3: When `lock` is high, a write leaves the stretch enable unchanged. The same write still updates the other fields.
- R4: Every write stores `wr_data[5:4]` into the duration field. The duration field appears at `rd_data[5:4]` and on `stretch_len`, and `lock` does not affect it.
- R5: The battery bit sits at `rd_data[2]`. A write with bit 2 at 0 clears it and a write with bit 2 at 1 leaves it unchanged. Only an always-on reset sets it again.
- R6: The power-failure bit sits at `rd_data[1]`. A write with bit 1 at 1 clears it and a write with bit 1 at 0 leaves it unchanged.
- R7: When `trickle_fail` is high at a clock edge, the power-failure bit is set at that edge. This wins over a clear written in the same cycle.
- R8: In the standby variant, `sby_rst_n` is sampled through two clock stages. A low value seen at the second stage sets the power-failure bit one edge later. The standby reset does not change the other fields. In the always-on variant, `sby_rst_n` has no effect.
- R9: A low pulse on `sby_rst_n` that begins and ends between two rising clock edges has no effect.
- R10: Bits 0, 6 and 7 of `rd_data` always read 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on real-time clock |
| rtc_rst_n | input | 1 | Always-on domain reset, active low, asynchronous assertion |
| sby_rst_n | input | 1 | Standby domain reset, active low, sampled on `clk` |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| lock | input | 1 | Policy lock, freezes the stretch enable |
| trickle_fail | input | 1 | Trickle-current loss indication, level |
| rd_data | output | 8 | Register read value |
| stretch_en | output | 1 | Stretch enable to the sleep-signal timing logic |
| stretch_len | output | 2 | Stretch duration select |

## Verification
The bench drives several writes with every byte lane set, including the reserved bits. A design that gave the bits a uniform clear rule would then show a status bit that moves on the wrong polarity, or a reserved bit that reads back 1. A write under lock checks that only the stretch enable is frozen; a design that gated the whole write would also freeze the duration. Trickle loss is raised in the same cycle as a clear, so a design with the wrong priority drops the status bit. A standby reset pulse that falls entirely between two edges must be missed, while a held standby reset must set only the standby-variant bit. A design that cleared other fields, or let the always-on variant react, shows up as a mismatch against the per-cycle model.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
  localparam int REG_W  = 8;
  localparam int PF_BIT = 1;
  localparam int BW_BIT = 2;
  localparam int SE_BIT = 3;
  localparam int SL_LSB = 4;
  localparam int SL_W   = 2;
  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'((((1 << SL_W) - 1) << SL_LSB) | (1 << SE_BIT) | (1 << BW_BIT) | (1 << PF_BIT));
endpackage

// File: rtl/pm_sync_chain.sv
module pm_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d[0] = d;
    for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= '0;
    else         st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pm_cfg_fields.sv
module pm_cfg_fields
  import pm_cfg_pkg::*;
#(
  parameter bit PF_IN_STANDBY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sby_ok,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock,
  input  logic             trickle_fail,
  output logic [REG_W-1:0] rd_data,
  output logic             stretch_en,
  output logic [SL_W-1:0]  stretch_len
);
  localparam logic PF_RST = PF_IN_STANDBY;

  logic            se_q, se_d, se_ce;
  logic [SL_W-1:0] sl_q, sl_d;
  logic            bw_q, bw_d, bw_ce;
  logic            pf_q, pf_d, pf_clr;
  logic            pf_set;

  generate
    if (PF_IN_STANDBY) begin : g_sby
      assign pf_set = trickle_fail | ~sby_ok;
      // R8
      sby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sby_ok |=> pf_q);
    end else begin : g_rtc
      assign pf_set = trickle_fail;
      logic unused_sby;
      assign unused_sby = sby_ok;
    end
  endgenerate

  always_comb begin
    se_ce  = wr_en & ~lock;
    bw_ce  = wr_en & ~wr_data[BW_BIT];
    pf_clr = wr_en & wr_data[PF_BIT];
    se_d   = se_ce ? wr_data[SE_BIT] : se_q;
    sl_d   = wr_en ? wr_data[SL_LSB +: SL_W] : sl_q;
    bw_d   = bw_ce ? 1'b0 : bw_q;
    if (pf_set)      pf_d = 1'b1;
    else if (pf_clr) pf_d = 1'b0;
    else             pf_d = pf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_q <= 1'b0;
      sl_q <= '0;
      bw_q <= 1'b1;
      pf_q <= PF_RST;
    end else begin
      se_q <= se_d;
      sl_q <= sl_d;
      bw_q <= bw_d;
      pf_q <= pf_d;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[PF_BIT]          = pf_q;
    rd_data[BW_BIT]          = bw_q;
    rd_data[SE_BIT]          = se_q;
    rd_data[SL_LSB +: SL_W]  = sl_q;
  end

  assign stretch_en  = se_q;
  assign stretch_len = sl_q;

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(stretch_en));
  // R4
  len_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stretch_len == $past(wr_data[SL_LSB +: SL_W])));
  // R5
  batt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bw_q));
  // R6
  pf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[PF_BIT] && !pf_set) |=> !pf_q);
  // R7
  pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trickle_fail |=> pf_q);
endmodule

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
  import pm_cfg_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter bit PF_IN_STANDBY = 1'b1
) (
  input  logic             clk,
  input  logic             rtc_rst_n,
  input  logic             sby_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock,
  input  logic             trickle_fail,
  output logic [REG_W-1:0] rd_data,
  output logic             stretch_en,
  output logic [SL_W-1:0]  stretch_len
);
  logic rst_n;
  logic sby_ok;

  pm_sync_chain #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(rtc_rst_n), .d(1'b1), .q(rst_n)
  );

  pm_sync_chain #(.STAGES(SYNC_STAGES)) u_sby_smp (
    .clk(clk), .arst_n(rst_n), .d(sby_rst_n), .q(sby_ok)
  );

  pm_cfg_fields #(.PF_IN_STANDBY(PF_IN_STANDBY)) u_fields (
    .clk(clk), .rst_n(rst_n), .sby_ok(sby_ok),
    .wr_en(wr_en), .wr_data(wr_data), .lock(lock),
    .trickle_fail(trickle_fail), .rd_data(rd_data),
    .stretch_en(stretch_en), .stretch_len(stretch_len)
  );

  // R10
  always_comb begin
    rsvd_zero_chk: assert ((rd_data & ~LIVE_MASK) == '0 || $isunknown(rd_data));
  end
endmodule

// File: tb/pm_cfg_reg_test.sv
module pm_cfg_reg_test;
  logic       clk = 1'b0;
  logic       rtc_rst_n;
  logic       sby_rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       lock;
  logic       trickle_fail;
  logic [7:0] rd_a, rd_b;
  logic       se_a, se_b;
  logic [1:0] sl_a, sl_b;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  pm_cfg_reg uut (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .sby_rst_n(sby_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .lock(lock), .trickle_fail(trickle_fail),
    .rd_data(rd_a), .stretch_en(se_a), .stretch_len(sl_a)
  );

  pm_cfg_reg #(.PF_IN_STANDBY(1'b0)) uut_rtc (
    .clk(clk), .rtc_rst_n(rtc_rst_n), .sby_rst_n(sby_rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .lock(lock), .trickle_fail(trickle_fail),
    .rd_data(rd_b), .stretch_en(se_b), .stretch_len(sl_b)
  );

  // behavioural reference
  int   m_cnt;
  bit   m_en, m_batt, m_pfa, m_pfb, m_s0, m_s1;
  int   m_len;

  always @(posedge clk or negedge rtc_rst_n) begin
    if (!rtc_rst_n) begin
      m_en = 0; m_len = 0; m_batt = 1; m_pfa = 1; m_pfb = 0;
      m_cnt = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      if (m_cnt == 2) begin
        if (wr_en && !lock) m_en = wr_data[3];
        if (wr_en) m_len = int'(wr_data[5:4]);
        if (wr_en && !wr_data[2]) m_batt = 0;
        if (trickle_fail || !m_s1) m_pfa = 1;
        else if (wr_en && wr_data[1]) m_pfa = 0;
        if (trickle_fail) m_pfb = 1;
        else if (wr_en && wr_data[1]) m_pfb = 0;
        m_s1 = m_s0;
        m_s0 = sby_rst_n;
      end
      if (m_cnt < 2) m_cnt++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input bit pf);
    return (m_len << 4) | (int'(m_en) << 3) | (int'(m_batt) << 2) | (int'(pf) << 1);
  endfunction

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check("R1/R5 batt field", int'(rd_a[2]), int'(m_batt));
      check("R2/R3 stretch enable", int'(se_a), int'(m_en));
      check("R2 stretch enable read", int'(rd_b[3]), int'(m_en));
      check("R4 stretch length", int'(sl_a), m_len);
      check("R4 stretch length rtc", int'(sl_b), m_len);
      check("R6/R7/R8 power fail standby", int'(rd_a[1]), int'(m_pfa));
      check("R6/R7/R8 power fail rtc", int'(rd_b[1]), int'(m_pfb));
      check("R10 reserved bits", int'(rd_a & 8'hC1), 0);
      check("R10 full read rtc", int'(rd_b), exp_rd(m_pfb));
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rtc_rst_n = 1'b1; sby_rst_n = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
    lock = 1'b0; trickle_fail = 1'b0;
    #1 rtc_rst_n = 1'b0;
    idle(3);
    cmp_on = 1;
    // R1 reset values
    check("R1 reset read standby", int'(rd_a), 'h06);
    check("R1 reset read rtc", int'(rd_b), 'h04);
    check("R1 reset stretch outputs", int'({se_a, sl_a}), 0);
    rtc_rst_n = 1'b1;
    idle(4);
    // R2 R4 R10 write with every bit set except the W1C bit
    wr(8'hFD);
    check("R2/R4/R10 write FD standby", int'(rd_a), 'h3E);
    check("R2/R4/R10 write FD rtc", int'(rd_b), 'h3C);
    // R5 R6 clear both status bits
    wr(8'h02);
    check("R5/R6 clears standby", int'(rd_a), 'h00);
    check("R5/R6 clears rtc", int'(rd_b), 'h00);
    // R3 lock freezes only the enable
    lock = 1'b1;
    wr(8'h18);
    check("R3 locked write", int'(rd_a), 'h10);
    lock = 1'b0;
    // R5 writing one keeps batt cleared
    wr(8'h1C);
    check("R5 write one no effect", int'(rd_a), 'h18);
    // R7 trickle set wins over clear
    @(negedge clk); trickle_fail = 1'b1; wr_en = 1'b1; wr_data = 8'h1A;
    @(negedge clk); trickle_fail = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    check("R7 set beats clear standby", int'(rd_a), 'h1A);
    check("R7 set beats clear rtc", int'(rd_b), 'h1A);
    // R6 write zero leaves it set
    wr(8'h18);
    check("R6 write zero no effect", int'(rd_a[1]), 1);
    wr(8'h1A);
    check("R6 write one clears", int'(rd_a), 'h18);
    // R9 glitch between edges
    @(negedge clk); #0.5 sby_rst_n = 1'b0; #1 sby_rst_n = 1'b1;
    idle(4);
    check("R9 glitch missed standby", int'(rd_a), 'h18);
    // R8 held standby reset
    sby_rst_n = 1'b0;
    idle(4);
    sby_rst_n = 1'b1;
    idle(3);
    check("R8 standby forces pf", int'(rd_a), 'h1A);
    check("R8 rtc variant ignores", int'(rd_b), 'h18);
    // R1 again after use
    @(negedge clk); rtc_rst_n = 1'b0;
    idle(1);
    check("R1 rearm standby", int'(rd_a), 'h06);
    check("R1 rearm rtc", int'(rd_b), 'h04);
    rtc_rst_n = 1'b1;
    idle(4);
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wr_en        = ($urandom % 3) == 0;
      wr_data      = 8'($urandom);
      lock         = ($urandom % 2) == 0;
      trickle_fail = ($urandom % 10) == 0;
      sby_rst_n    = ($urandom % 12) != 0;
      rtc_rst_n    = ($urandom % 150) != 0;
    end
    @(negedge clk);
    rtc_rst_n = 1'b1; sby_rst_n = 1'b1; wr_en = 1'b0;
    idle(4);
    finish_up();
  end
endmodule